// File: doc/BRIEF.md
# Priority DMA Channel Arbiter

This block decides which of eight DMA channels owns the transfer engine for the next single data item. A single data item is one read followed by one write. Each channel presents an enable, a two-bit priority level, a flag that marks it as a software-started memory-to-memory channel, an indication that its remaining item count is nonzero, and a request line from its peripheral. The arbiter registers its choice on a grant index with a grant-valid level. It holds that grant until the transfer engine pulses done. It then arbitrates again, so every single item is a fresh decision.

Peripheral channels use a four-phase handshake. Acknowledge rises together with the grant. The peripheral then withdraws its request. Acknowledge falls once the request is seen low, and the channel can compete again only after that. Memory-to-memory channels need no request and never see an acknowledge. A memory-to-memory channel also gives way to any other eligible channel after each of its items, whatever that channel's priority.

Top module: `dma_prio_arbiter`

## Requirements
- R1: After reset, grant-valid is low and every acknowledge line is low.
- R2: Among eligible channels, the one with the highest priority level wins. The level encoding is 2'b00 low, 2'b01 medium, 2'b10 high and 2'b11 very high. Channel c's level sits in bits [2c+1:2c] of the priority bus.
- R3: When eligible channels share the highest level, the lowest channel index wins.
- R4: An enabled memory-to-memory channel with a nonzero count is eligible without any request on its request line.
- R5: A channel whose nonzero-count input is low is never granted.
- R6: A channel whose enable input is low is never granted. A channel switched off after a transfer error is presented with its enable low.
- R7: A granted peripheral channel has its acknowledge high in the same cycle that grant-valid first shows the grant. A memory-to-memory channel is never acknowledged.
- R8: Acknowledge stays high while the channel's request stays high. It falls on the clock edge that samples the request low.
- R9: A peripheral channel whose acknowledge is still high is not eligible, even if its request stays high.
- R10: If the previous grant went to a memory-to-memory channel and any other channel is eligible, the next grant goes to another channel, even one of lower priority. If no other channel is eligible, the same memory-to-memory channel is granted again.
- R11: A grant keeps its index and its valid level until a done pulse. Grant-valid is low for exactly the one cycle after the done pulse. A waiting eligible channel is granted on the edge after that cycle. A done pulse with no grant outstanding has no effect.
- R12: With no eligible channel, grant-valid stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_en | input | NUM_CH | Per-channel enable; low while disabled or after an error |
| ch_prio | input | 2*NUM_CH | Per-channel priority level, two bits per channel |
| ch_mem2mem | input | NUM_CH | Per-channel software-started memory-to-memory flag |
| ch_cnt_nz | input | NUM_CH | Per-channel remaining count is nonzero |
| ch_req | input | NUM_CH | Per-channel peripheral request |
| xfer_done | input | 1 | One-cycle pulse from the transfer engine ending the current item |
| gnt_idx | output | $clog2(NUM_CH) | Index of the granted channel |
| gnt_valid | output | 1 | High while a grant is outstanding |
| ch_ack | output | NUM_CH | Per-channel acknowledge to the peripheral |

## Verification
The hardest situation to reach is the yield of a memory-to-memory channel. It needs a very-high-priority software channel already holding a grant, with a low-priority peripheral request arriving during that item, so that the next arbitration sees both. The stimulus raises the peripheral request while the software channel is mid-transfer. It then ends the item with a done pulse and checks that the lower-priority channel is chosen. After that peripheral's item, it checks that the software channel takes back the grant. A second hard case is a peripheral that keeps its request high after being acknowledged. The bench holds the request through the done pulse and watches the block stay idle until the request drops and comes back.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int PRIO_W = 2;
  typedef logic [PRIO_W-1:0] prio_t;
  typedef enum logic {ST_ARB = 1'b0, ST_XFER = 1'b1} arb_state_e;

  // Level of channel c taken from the packed priority bus
  function automatic prio_t level_of(input logic [63:0] bus, input int c);
    return prio_t'(bus >> (c * PRIO_W));
  endfunction
endpackage

// File: rtl/dma_arb_elig.sv
module dma_arb_elig
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0] en,
  input  logic [NUM_CH-1:0] m2m,
  input  logic [NUM_CH-1:0] cnt_nz,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] ack,
  input  logic              last_m2m,
  input  logic [IW-1:0]     last_idx,
  output logic [NUM_CH-1:0] elig,
  output logic [NUM_CH-1:0] cand
);
  logic [NUM_CH-1:0] last_oh;
  logic [NUM_CH-1:0] others;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    // Software channels need no request; peripheral ones need a fresh request
    assign elig[c]    = en[c] & cnt_nz[c] & (m2m[c] | (req[c] & ~ack[c]));
    assign last_oh[c] = last_m2m & (last_idx == IW'(c));
  end

  assign others = elig & ~last_oh;
  // Yield the last software channel only when someone else is waiting
  assign cand   = (|others) ? others : elig;
endmodule

// File: rtl/dma_arb_pick.sv
module dma_arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic [NUM_CH-1:0]        cand,
  input  logic [NUM_CH*PRIO_W-1:0] prio,
  output logic [IW-1:0]            win,
  output logic                     any
);
  logic [63:0] prio_wide;
  prio_t       best;

  assign prio_wide = 64'(prio);

  // Strictly greater keeps the lower index on a tie
  always_comb begin
    win  = '0;
    any  = 1'b0;
    best = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (cand[c] && (!any || level_of(prio_wide, c) > best)) begin
        win  = IW'(c);
        best = level_of(prio_wide, c);
        any  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_arb_ack.sv
module dma_arb_ack #(
  parameter int NUM_CH = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant_fire,
  input  logic [IW-1:0]     win,
  input  logic [NUM_CH-1:0] m2m,
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] ack
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_hs
    logic set_ack;
    logic clr_ack;
    assign set_ack = grant_fire & (win == IW'(c)) & ~m2m[c];
    assign clr_ack = ack[c] & ~req[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ack[c] <= 1'b0;
      else if (set_ack) ack[c] <= 1'b1;
      else if (clr_ack) ack[c] <= 1'b0;
    end
  end
endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_CH-1:0]        ch_en,
  input  logic [NUM_CH*PRIO_W-1:0] ch_prio,
  input  logic [NUM_CH-1:0]        ch_mem2mem,
  input  logic [NUM_CH-1:0]        ch_cnt_nz,
  input  logic [NUM_CH-1:0]        ch_req,
  input  logic                     xfer_done,
  output logic [IW-1:0]            gnt_idx,
  output logic                     gnt_valid,
  output logic [NUM_CH-1:0]        ch_ack
);
  arb_state_e        state_q;
  logic              last_m2m_q;
  logic [NUM_CH-1:0] elig;
  logic [NUM_CH-1:0] cand;
  logic [IW-1:0]     win_idx;
  logic              any_cand;
  logic              grant_fire;
  logic              grant_end;

  dma_arb_elig #(.NUM_CH(NUM_CH), .IW(IW)) u_elig (
    .en       (ch_en),
    .m2m      (ch_mem2mem),
    .cnt_nz   (ch_cnt_nz),
    .req      (ch_req),
    .ack      (ch_ack),
    .last_m2m (last_m2m_q),
    .last_idx (gnt_idx),
    .elig     (elig),
    .cand     (cand)
  );

  dma_arb_pick #(.NUM_CH(NUM_CH), .IW(IW)) u_pick (
    .cand (cand),
    .prio (ch_prio),
    .win  (win_idx),
    .any  (any_cand)
  );

  dma_arb_ack #(.NUM_CH(NUM_CH), .IW(IW)) u_ack (
    .clk        (clk),
    .rst_n      (rst_n),
    .grant_fire (grant_fire),
    .win        (win_idx),
    .m2m        (ch_mem2mem),
    .req        (ch_req),
    .ack        (ch_ack)
  );

  assign grant_fire = (state_q == ST_ARB) & any_cand;
  assign grant_end  = (state_q == ST_XFER) & xfer_done;
  assign gnt_valid  = (state_q == ST_XFER);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_ARB;
      gnt_idx    <= '0;
      last_m2m_q <= 1'b0;
    end else if (grant_fire) begin
      state_q    <= ST_XFER;
      gnt_idx    <= win_idx;
      last_m2m_q <= ch_mem2mem[win_idx];
    end else if (grant_end) begin
      state_q    <= ST_ARB;
    end
  end
endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk #(
  parameter int NUM_CH = 8,
  parameter int IW     = $clog2(NUM_CH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_CH-1:0] ch_en,
  input logic [NUM_CH-1:0] ch_mem2mem,
  input logic [NUM_CH-1:0] ch_cnt_nz,
  input logic [NUM_CH-1:0] ch_req,
  input logic              xfer_done,
  input logic [IW-1:0]     gnt_idx,
  input logic              gnt_valid,
  input logic [NUM_CH-1:0] ch_ack,
  input logic              grant_fire,
  input logic [IW-1:0]     win_idx,
  input logic [NUM_CH-1:0] elig
);
  assert_live_chan_R5: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ch_cnt_nz[win_idx]);

  assert_enabled_chan_R6: assert property (@(posedge clk) disable iff (!rst_n)
    grant_fire |-> ch_en[win_idx]);

  assert_ack_with_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_fire && !ch_mem2mem[win_idx]) |=> (gnt_valid && ch_ack[gnt_idx]));

  assert_grant_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && !xfer_done) |=> (gnt_valid && $stable(gnt_idx)));

  assert_grant_gap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid && xfer_done) |=> !gnt_valid);

  assert_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!gnt_valid && !(|elig)) |=> !gnt_valid);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_hs
    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ack[c] && ch_req[c]) |=> ch_ack[c]);
    assert_ack_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_ack[c] && !ch_req[c]) |=> !ch_ack[c]);
  end
endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NUM_CH(NUM_CH), .IW(IW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .ch_mem2mem (ch_mem2mem),
  .ch_cnt_nz  (ch_cnt_nz),
  .ch_req     (ch_req),
  .xfer_done  (xfer_done),
  .gnt_idx    (gnt_idx),
  .gnt_valid  (gnt_valid),
  .ch_ack     (ch_ack),
  .grant_fire (grant_fire),
  .win_idx    (win_idx),
  .elig       (elig)
);

// File: tb/dma_prio_arbiter_tb.sv
module dma_prio_arbiter_tb_top;
  localparam int N  = 8;
  localparam int IW = 3;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] en = '0, m2m = '0, nz = '0, req = '0;
  logic [2*N-1:0] prio = '0;
  logic         done = 1'b0;
  logic [IW-1:0] gnt_idx;
  logic         gnt_valid;
  logic [N-1:0] ack;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  dma_prio_arbiter #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ch_en(en), .ch_prio(prio),
    .ch_mem2mem(m2m), .ch_cnt_nz(nz), .ch_req(req),
    .xfer_done(done), .gnt_idx(gnt_idx), .gnt_valid(gnt_valid), .ch_ack(ack)
  );

  task automatic chk(input string rq, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = '0; m2m = '0; nz = '0; req = '0; prio = '0; done = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic setup(input int c, input int lvl, input bit is_m2m, input bit r);
    en[c] = 1'b1; nz[c] = 1'b1; m2m[c] = is_m2m; req[c] = r;
    prio[2*c +: 2] = 2'(lvl);
  endtask

  task automatic wait_grant(output int idx);
    idx = -1;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (gnt_valid) begin idx = int'(gnt_idx); break; end
    end
  endtask

  task automatic end_xfer();
    done = 1'b1;
    @(negedge clk);
    done = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 grant-valid", int'(gnt_valid), 0);
    chk("R1 ack", int'(ack), 0);
  endtask

  task automatic t_priority();
    int g;
    do_reset();
    setup(2, 1, 0, 1); setup(5, 3, 0, 1); setup(6, 2, 0, 1);
    wait_grant(g);
    chk("R2 very high wins", g, 5);
    chk("R7 ack with grant", int'(ack[5]), 1);
    repeat (2) @(negedge clk);
    chk("R8 ack held", int'(ack[5]), 1);
    chk("R11 index held", int'(gnt_idx), 5);
    req[5] = 1'b0;
    @(negedge clk);
    chk("R8 ack released", int'(ack[5]), 0);
    chk("R11 valid held", int'(gnt_valid), 1);
    end_xfer();
    chk("R11 one idle cycle", int'(gnt_valid), 0);
    @(negedge clk);
    chk("R11 regrant", int'(gnt_valid), 1);
    chk("R2 high next", int'(gnt_idx), 6);
  endtask

  task automatic t_tie();
    int g;
    do_reset();
    setup(0, 1, 0, 1); setup(1, 2, 0, 1); setup(3, 2, 0, 1);
    wait_grant(g);
    chk("R3 lower index on tie", g, 1);
  endtask

  task automatic t_masks();
    int g;
    do_reset();
    setup(0, 3, 0, 1); en[0] = 1'b0;
    setup(4, 3, 0, 1); nz[4] = 1'b0;
    setup(5, 3, 1, 0); nz[5] = 1'b0;
    repeat (6) @(negedge clk);
    chk("R12 idle without eligible", int'(gnt_valid), 0);
    chk("R6 R5 no ack", int'(ack), 0);
    end_xfer();
    @(negedge clk);
    chk("R11 stray done ignored", int'(gnt_valid), 0);
    setup(7, 0, 0, 1);
    wait_grant(g);
    chk("R5 R6 only live channel", g, 7);
  endtask

  task automatic t_m2m();
    int g;
    do_reset();
    setup(0, 3, 1, 0);
    wait_grant(g);
    chk("R4 software channel granted", g, 0);
    chk("R7 no ack for software channel", int'(ack), 0);
    end_xfer();
    wait_grant(g);
    chk("R10 alone keeps grant", g, 0);
    setup(3, 0, 0, 1);
    end_xfer();
    wait_grant(g);
    chk("R10 yields to low priority", g, 3);
    req[3] = 1'b0;
    end_xfer();
    wait_grant(g);
    chk("R10 software channel resumes", g, 0);
  endtask

  task automatic t_reelig();
    int g;
    do_reset();
    setup(2, 0, 0, 1);
    wait_grant(g);
    chk("R7 peripheral granted", g, 2);
    end_xfer();
    repeat (5) @(negedge clk);
    chk("R9 held request not regranted", int'(gnt_valid), 0);
    chk("R8 ack still high", int'(ack[2]), 1);
    req[2] = 1'b0;
    @(negedge clk);
    chk("R8 ack falls", int'(ack[2]), 0);
    req[2] = 1'b1;
    wait_grant(g);
    chk("R9 fresh request granted", g, 2);
  endtask

  initial begin
    t_reset();
    t_priority();
    t_tie();
    t_masks();
    t_m2m();
    t_reelig();
    summary();
  end

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end
endmodule